// File: doc/BRIEF.md
# Multi-Lane Link Synchronization Handshake Receiver

This block runs the receive side of the start-up handshake on a multi-lane 8b/10b serial link. Each lane supplies one decoded character per clock, with a flag that marks control characters and a flag that marks decode or disparity errors. The block drives an active-low synchronization request back to the transmitter. It holds that request low until every lane has locked on comma characters. It then releases the request and waits for the alignment sequence, which must start on the next local multiframe boundary. While the sequence runs, the block checks the control markers and compares the link parameters carried in the sequence against the locally configured values.

The local multiframe counter advances one octet position per clock and restarts at zero on every multiframe. It starts from reset, so a transmitter that shares the same reference can predict the boundary exactly. A marker fault, a configuration mismatch, or a lane that loses lock after release drops the request again and restarts the whole handshake. The offending lane is flagged in a sticky error vector, and a sticky flag records any configuration mismatch. Once the alignment sequence completes cleanly, the link-up output rises and stays high until a lane loses lock.

Top module: `link_sync_rx`

## Requirements
- R1: While reset is held and immediately after it is released, sync_n is 0, link_up is 0, lane_err is all zeros and cfg_mismatch is 0.
- R2: A lane locks after LOCK_COUNT (default 4) consecutive clocks that carry the comma code 0xBC with the control flag set and the error flag clear. Before lock, any other character, or any error flag, restarts that lane's count at zero. sync_n rises on the clock after the last lane locks, provided R3 is already met.
- R3: Every time sync_n goes low, it stays low for at least MIN_LOW = FRAME_OCTETS*SYNC_MIN_FRAMES clocks (default 8). When all lanes lock early, it is low for exactly that many clocks.
- R4: The local multiframe position equals the number of clocks since reset modulo FRAME_OCTETS*FRAMES_PER_MF (default 8). After sync_n rises, the first clock at position 0 must carry the first octet of the alignment sequence. If it does not, that lane is flagged and the handshake restarts.
- R5: The alignment sequence lasts ILA_MULTIFRAMES multiframes (default 4). In every multiframe, position 0 is the control code 0x1C and the last position is the control code 0x7C. In the second multiframe, position 1 is the control code 0x9C. A wrong marker drops sync_n on the next clock and sets that lane's lane_err bit.
- R6: In the second multiframe, positions 2 to 6 carry five configuration octets, in this order: F-1 (8 bits), K-1 (low 5 bits), L-1 (low 5 bits), M-1 (8 bits) and subclass (low 3 bits). The unused upper bits are ignored. At the end of the sequence, a difference from the local cfg_* inputs on any lane drops sync_n, sets cfg_mismatch and sets that lane's lane_err bit.
- R7: A sequence with no marker or configuration fault raises link_up on the clock after its last octet. link_up is 0 at all other times during the handshake.
- R8: Once sync_n is high, an error flag on a locked lane drops sync_n and link_up on the next clock and sets that lane's lane_err bit.
- R9: lane_err bits and cfg_mismatch are sticky until reset.
- R10: After any restart, the full handshake (lock, minimum low time, alignment) runs again and can bring the link up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_char | input | LANES*8 | Decoded character per lane, lane i at bits [8i+7:8i] |
| rx_is_k | input | LANES | Control-character flag per lane |
| rx_err | input | LANES | Decode or disparity error flag per lane |
| cfg_octets_m1 | input | 8 | Local octets per frame minus one |
| cfg_frames_m1 | input | 5 | Local frames per multiframe minus one |
| cfg_lanes_m1 | input | 5 | Local lane count minus one |
| cfg_conv_m1 | input | 8 | Local converter count minus one |
| cfg_subclass | input | 3 | Local subclass |
| sync_n | output | 1 | Active-low synchronization request |
| link_up | output | 1 | Handshake complete, data phase |
| lane_err | output | LANES | Sticky per-lane fault flags |
| cfg_mismatch | output | 1 | Sticky configuration mismatch flag |

## Verification
The comma lock is tested with two patterns. In the first, both lanes carry clean commas from the first clock, which shows the minimum low time governing the release. In the second, one lane carries an error-flagged comma and then commas without the control flag, which shows the lock count restarting and sets the release to one clock after the late lane locks. The alignment phase is tested with several sequences. A clean sequence separates correct marker and boundary handling from the faulty cases. A missing end marker on one lane, a wrong frames-per-multiframe field on the other lane, and a start shifted one octet past the boundary each show which lane is blamed and whether the mismatch flag is raised. A sequence with junk in the ignored upper field bits shows that masked bits play no part. An error on a locked lane in the data phase, followed by a full re-handshake, shows that the restart path recovers and that the flags stay sticky.

// File: rtl/lsh_pkg.sv
package lsh_pkg;

   localparam logic [7:0] CH_COMMA   = 8'hBC;
   localparam logic [7:0] CH_START   = 8'h1C;
   localparam logic [7:0] CH_MF_END  = 8'h7C;
   localparam logic [7:0] CH_CFG_TAG = 8'h9C;

   localparam int CFG_NUM   = 5;
   localparam int CFG_FIRST = 2;

   typedef enum logic [1:0] {
      HS_LOW,
      HS_WAIT,
      HS_ALIGN,
      HS_DATA
   } hs_state_e;

   function automatic logic [7:0] cfg_mask(input int idx);
      case (idx)
         0: cfg_mask = 8'hFF;
         1: cfg_mask = 8'h1F;
         2: cfg_mask = 8'h1F;
         3: cfg_mask = 8'hFF;
         default: cfg_mask = 8'h07;
      endcase
   endfunction

endpackage

// File: rtl/lsh_lmfc.sv
module lsh_lmfc #(
   parameter int MF_LEN = 8,
   localparam int PW = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [PW-1:0] pos,
   output logic          last
);

   assign last = (pos == PW'(MF_LEN - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (last) begin
         pos <= '0;
      end else begin
         pos <= pos + 1'b1;
      end
   end

endmodule

// File: rtl/lsh_lane_cgs.sv
module lsh_lane_cgs
   import lsh_pkg::*;
#(
   parameter int LOCK_COUNT = 4,
   localparam int CW = $clog2(LOCK_COUNT + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic [7:0] ch,
   input  logic       is_k,
   input  logic       err,
   output logic       locked,
   output logic       lost
);

   logic [CW-1:0] run;
   logic          good_comma;

   assign good_comma = is_k && !err && (ch == CH_COMMA);
   assign lost       = locked && err;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         run    <= '0;
         locked <= 1'b0;
      end else if (!locked) begin
         if (!good_comma) begin
            run <= '0;
         end else if (run == CW'(LOCK_COUNT - 1)) begin
            locked <= 1'b1;
            run    <= '0;
         end else begin
            run <= run + 1'b1;
         end
      end else if (err) begin
         locked <= 1'b0;
         run    <= '0;
      end
   end

endmodule

// File: rtl/lsh_lane_align.sv
module lsh_lane_align
   import lsh_pkg::*;
#(
   parameter int PW = 3,
   parameter int MW = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 active,
   input  logic [MW-1:0]        mf_idx,
   input  logic [PW-1:0]        pos,
   input  logic                 pos_last,
   input  logic [7:0]           ch,
   input  logic                 is_k,
   input  logic [CFG_NUM*8-1:0] expect_cfg,
   output logic                 marker_err,
   output logic                 cfg_bad
);

   logic       need_k;
   logic [7:0] want_ch;
   logic [CFG_NUM-1:0] field_bad;

   always_comb begin
      need_k  = 1'b1;
      want_ch = CH_START;
      if (pos == '0) begin
         want_ch = CH_START;
      end else if (pos_last) begin
         want_ch = CH_MF_END;
      end else if (mf_idx == MW'(1) && pos == PW'(1)) begin
         want_ch = CH_CFG_TAG;
      end else begin
         need_k = 1'b0;
      end
   end

   assign marker_err = active && need_k && !(is_k && ch == want_ch);

   for (genvar gi = 0; gi < CFG_NUM; gi++) begin : g_field
      logic [7:0] held;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            held <= '0;
         end else if (active && mf_idx == MW'(1) && pos == PW'(CFG_FIRST + gi)) begin
            held <= ch;
         end
      end
      assign field_bad[gi] = |((held ^ expect_cfg[gi*8 +: 8]) & cfg_mask(gi));
   end

   assign cfg_bad = |field_bad;

endmodule

// File: rtl/link_sync_rx.sv
module link_sync_rx
   import lsh_pkg::*;
#(
   parameter int LANES           = 2,
   parameter int FRAME_OCTETS    = 2,
   parameter int FRAMES_PER_MF   = 4,
   parameter int LOCK_COUNT      = 4,
   parameter int ILA_MULTIFRAMES = 4,
   parameter int SYNC_MIN_FRAMES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LANES*8-1:0] rx_char,
   input  logic [LANES-1:0]   rx_is_k,
   input  logic [LANES-1:0]   rx_err,
   input  logic [7:0]         cfg_octets_m1,
   input  logic [4:0]         cfg_frames_m1,
   input  logic [4:0]         cfg_lanes_m1,
   input  logic [7:0]         cfg_conv_m1,
   input  logic [2:0]         cfg_subclass,
   output logic               sync_n,
   output logic               link_up,
   output logic [LANES-1:0]   lane_err,
   output logic               cfg_mismatch
);

   localparam int MF_LEN  = FRAME_OCTETS * FRAMES_PER_MF;
   localparam int PW      = (MF_LEN > 1) ? $clog2(MF_LEN) : 1;
   localparam int MW      = $clog2(ILA_MULTIFRAMES);
   localparam int MIN_LOW = FRAME_OCTETS * SYNC_MIN_FRAMES;
   localparam int LW      = $clog2(MIN_LOW + 1);

   if (MF_LEN < CFG_FIRST + CFG_NUM + 1) begin : g_chk_mf
      $error("multiframe too short for configuration octets");
   end
   if (ILA_MULTIFRAMES < 2) begin : g_chk_ila
      $error("alignment needs at least two multiframes");
   end
   if (LANES < 1 || LANES > 32) begin : g_chk_lanes
      $error("LANES out of range");
   end
   if (LOCK_COUNT < 1 || SYNC_MIN_FRAMES < 1) begin : g_chk_cnt
      $error("counts must be positive");
   end

   hs_state_e state, state_nx;
   logic [PW-1:0] pos;
   logic          pos_last;
   logic [MW-1:0] mf_idx;
   logic          low_done;
   logic          align_on;
   logic          align_end;
   logic          restart;
   logic          all_locked;
   logic [LANES-1:0] lane_locked, lane_lost, lane_mark, lane_cfg;
   logic [LANES-1:0] bad_mark, bad_cfg, bad_lost, bad_any;
   logic [CFG_NUM*8-1:0] expect_cfg;
   logic [MW-1:0] mf_use;

   assign expect_cfg = {5'b0, cfg_subclass,
                        cfg_conv_m1,
                        3'b0, cfg_lanes_m1,
                        3'b0, cfg_frames_m1,
                        cfg_octets_m1};

   lsh_lmfc #(.MF_LEN(MF_LEN)) u_lmfc (
      .clk   (clk),
      .rst_n (rst_n),
      .pos   (pos),
      .last  (pos_last)
   );

   assign align_on  = (state == HS_WAIT && pos == '0) || (state == HS_ALIGN);
   assign mf_use    = (state == HS_ALIGN) ? mf_idx : '0;
   assign align_end = (state == HS_ALIGN) && pos_last
                      && (mf_idx == MW'(ILA_MULTIFRAMES - 1));

   for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
      lsh_lane_cgs #(.LOCK_COUNT(LOCK_COUNT)) u_cgs (
         .clk    (clk),
         .rst_n  (rst_n),
         .clear  (restart),
         .ch     (rx_char[gl*8 +: 8]),
         .is_k   (rx_is_k[gl]),
         .err    (rx_err[gl]),
         .locked (lane_locked[gl]),
         .lost   (lane_lost[gl])
      );
      lsh_lane_align #(.PW(PW), .MW(MW)) u_align (
         .clk        (clk),
         .rst_n      (rst_n),
         .active     (align_on),
         .mf_idx     (mf_use),
         .pos        (pos),
         .pos_last   (pos_last),
         .ch         (rx_char[gl*8 +: 8]),
         .is_k       (rx_is_k[gl]),
         .expect_cfg (expect_cfg),
         .marker_err (lane_mark[gl]),
         .cfg_bad    (lane_cfg[gl])
      );
   end

   if (LANES == 1) begin : g_one
      assign all_locked = lane_locked[0];
   end else begin : g_many
      assign all_locked = &lane_locked;
   end

   assign bad_mark = lane_mark & {LANES{align_on}};
   assign bad_cfg  = lane_cfg & {LANES{align_end}};
   assign bad_lost = lane_lost & {LANES{state != HS_LOW}};
   assign bad_any  = bad_mark | bad_cfg | bad_lost;
   assign restart  = |bad_any;

   if (MIN_LOW == 1) begin : g_nolow
      assign low_done = 1'b1;
   end else begin : g_lowcnt
      logic [LW-1:0] low_cnt;
      always_ff @(posedge clk) begin
         if (!rst_n || state != HS_LOW) begin
            low_cnt <= '0;
         end else if (low_cnt != LW'(MIN_LOW - 1)) begin
            low_cnt <= low_cnt + 1'b1;
         end
      end
      assign low_done = (low_cnt == LW'(MIN_LOW - 1));
   end

   always_comb begin
      state_nx = state;
      case (state)
         HS_LOW:   if (all_locked && low_done) state_nx = HS_WAIT;
         HS_WAIT:  if (restart) state_nx = HS_LOW;
                   else if (pos == '0) state_nx = HS_ALIGN;
         HS_ALIGN: if (restart) state_nx = HS_LOW;
                   else if (align_end) state_nx = HS_DATA;
         HS_DATA:  if (restart) state_nx = HS_LOW;
         default:  state_nx = HS_LOW;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= HS_LOW;
         mf_idx       <= '0;
         lane_err     <= '0;
         cfg_mismatch <= 1'b0;
      end else begin
         state        <= state_nx;
         lane_err     <= lane_err | bad_any;
         cfg_mismatch <= cfg_mismatch | (|bad_cfg);
         if (state != HS_ALIGN) begin
            mf_idx <= '0;
         end else if (pos_last) begin
            mf_idx <= mf_idx + 1'b1;
         end
      end
   end

   assign sync_n  = (state != HS_LOW);
   assign link_up = (state == HS_DATA);

endmodule

// File: rtl/lsh_checker.sv
module lsh_checker #(
   parameter int LANES           = 2,
   parameter int FRAME_OCTETS    = 2,
   parameter int SYNC_MIN_FRAMES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sync_n,
   input logic             link_up,
   input logic [LANES-1:0] lane_err,
   input logic             cfg_mismatch,
   input logic [LANES-1:0] lane_locked
);

   localparam int MIN_LOW = FRAME_OCTETS * SYNC_MIN_FRAMES;
   localparam int RW = $clog2(MIN_LOW + 2);

   logic [RW-1:0] low_run;

   always_ff @(posedge clk) begin
      if (!rst_n || sync_n) begin
         low_run <= '0;
      end else if (low_run != RW'(MIN_LOW + 1)) begin
         low_run <= low_run + 1'b1;
      end
   end

   a_r1_reset_outputs: assert property (@(posedge clk)
      !rst_n |=> (!sync_n && !link_up && lane_err == '0 && !cfg_mismatch));

   a_r2_release_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_n) |-> &$past(lane_locked));

   a_r3_min_low_time: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_n) |-> (low_run >= RW'(MIN_LOW)));

   a_r7_link_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
      link_up |-> sync_n);

   a_r5_err_drops_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_err != $past(lane_err)) |-> !sync_n);

   a_r8_link_drop_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_up) |-> !sync_n);

   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(lane_err) & ~lane_err) == '0));

   a_r9_mismatch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_mismatch) |-> cfg_mismatch);

endmodule

bind link_sync_rx lsh_checker #(
   .LANES           (LANES),
   .FRAME_OCTETS    (FRAME_OCTETS),
   .SYNC_MIN_FRAMES (SYNC_MIN_FRAMES)
) u_lsh_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .sync_n       (sync_n),
   .link_up      (link_up),
   .lane_err     (lane_err),
   .cfg_mismatch (cfg_mismatch),
   .lane_locked  (lane_locked)
);

// File: tb/link_sync_rx_tb_top.sv
`timescale 1ns/1ps
module link_sync_rx_tb_top;

   localparam int LANES   = 2;
   localparam int MF      = 8;
   localparam int ILA_MF  = 4;
   localparam int MIN_LOW = 8;
   localparam int NO_BAD  = 0;
   localparam int BAD_END = 1;
   localparam int BAD_K   = 2;
   localparam int HIGH_K  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [LANES*8-1:0] rx_char = '0;
   logic [LANES-1:0] rx_is_k = '0;
   logic [LANES-1:0] rx_err = '0;
   logic sync_n, link_up, cfg_mismatch;
   logic [LANES-1:0] lane_err;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   link_sync_rx dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_char       (rx_char),
      .rx_is_k       (rx_is_k),
      .rx_err        (rx_err),
      .cfg_octets_m1 (8'd1),
      .cfg_frames_m1 (5'd3),
      .cfg_lanes_m1  (5'd1),
      .cfg_conv_m1   (8'd1),
      .cfg_subclass  (3'd1),
      .sync_n        (sync_n),
      .link_up       (link_up),
      .lane_err      (lane_err),
      .cfg_mismatch  (cfg_mismatch)
   );

   task automatic check(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      cyc++;
      @(negedge clk);
   endtask

   task automatic put(input int lane, input logic [7:0] c, input logic k, input logic e);
      rx_char[lane*8 +: 8] = c;
      rx_is_k[lane] = k;
      rx_err[lane] = e;
   endtask

   task automatic commas();
      for (int l = 0; l < LANES; l++) put(l, 8'hBC, 1'b1, 1'b0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      for (int l = 0; l < LANES; l++) put(l, 8'h00, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc = 0;
   endtask

   // drive commas until sync_n rises; returns clocks spent low since start
   task automatic wait_release(output int low_len);
      int start;
      start = cyc;
      low_len = -1;
      for (int i = 0; i < 200; i++) begin
         if (sync_n) begin
            low_len = cyc - start;
            break;
         end
         commas();
         tick();
      end
   endtask

   function automatic logic [8:0] ila_char(input int lane, input int m, input int p,
                                           input int bad_lane, input int kind);
      logic [7:0] c;
      logic k;
      k = 1'b0;
      c = 8'(p + 8'h40);
      if (p == 0) begin c = 8'h1C; k = 1'b1; end
      else if (p == MF - 1) begin c = 8'h7C; k = 1'b1; end
      else if (m == 1 && p == 1) begin c = 8'h9C; k = 1'b1; end
      else if (m == 1 && p == 2) c = 8'd1;
      else if (m == 1 && p == 3) c = 8'd3;
      else if (m == 1 && p == 4) c = 8'd1;
      else if (m == 1 && p == 5) c = 8'd1;
      else if (m == 1 && p == 6) c = 8'd1;
      if (lane == bad_lane && kind == BAD_END && m == 2 && p == MF - 1) begin
         c = 8'h55; k = 1'b0;
      end
      if (lane == bad_lane && kind == BAD_K && m == 1 && p == 3) c = 8'd7;
      if (kind == HIGH_K && m == 1 && p == 3) c = 8'hE3;
      if (kind == HIGH_K && m == 1 && p == 6) c = 8'hF9;
      return {k, c};
   endfunction

   // commas up to boundary, then alignment sequence; stops after sync_n falls
   task automatic send_ila(input int bad_lane, input int kind, input int shift,
                           output logic fell);
      logic [8:0] v;
      fell = 1'b0;
      for (int i = 0; i < MF && ((cyc % MF) != 0); i++) begin
         commas();
         tick();
      end
      for (int s = 0; s < shift; s++) begin
         commas();
         tick();
      end
      for (int m = 0; m < ILA_MF && !fell; m++) begin
         for (int p = 0; p < MF && !fell; p++) begin
            if (m == ILA_MF - 1 && p == MF - 1) begin
               check(!link_up, "R7 link_up low before last octet", link_up, 0);
            end
            for (int l = 0; l < LANES; l++) begin
               v = ila_char(l, m, p, bad_lane, kind);
               put(l, v[7:0], v[8], 1'b0);
            end
            tick();
            if (!sync_n) fell = 1'b1;
         end
      end
   endtask

   task automatic t_reset();
      do_reset();
      check(!sync_n, "R1 sync_n after reset", sync_n, 0);
      check(!link_up, "R1 link_up after reset", link_up, 0);
      check(lane_err == 0, "R1 lane_err after reset", lane_err, 0);
      check(!cfg_mismatch, "R1 cfg_mismatch after reset", cfg_mismatch, 0);
   endtask

   task automatic t_fast_lock_and_clean();
      int len;
      logic fell;
      do_reset();
      wait_release(len);
      check(len == MIN_LOW, "R3 minimum low time with early lock", len, MIN_LOW);
      send_ila(-1, NO_BAD, 0, fell);
      check(!fell, "R5 clean sequence keeps sync_n high", fell, 0);
      check(link_up, "R7 link_up after clean sequence", link_up, 1);
      check(lane_err == 0, "R7 no lane_err on clean run", lane_err, 0);
      check(!cfg_mismatch, "R6 no mismatch on clean run", cfg_mismatch, 0);
   endtask

   task automatic t_slow_lock();
      int len;
      do_reset();
      for (int c = 0; c < 6; c++) begin
         put(0, 8'hBC, 1'b1, 1'b0);
         if (c < 3) put(1, 8'hBC, 1'b1, 1'b0);
         else if (c == 3) put(1, 8'hBC, 1'b1, 1'b1);
         else put(1, 8'hBC, 1'b0, 1'b0);
         tick();
      end
      check(!sync_n, "R2 sync_n low while lane 1 unlocked", sync_n, 0);
      wait_release(len);
      check(len == 5, "R2 release one clock after late lane locks", len, 5);
      check(lane_err == 0, "R2 pre-lock errors do not flag lane", lane_err, 0);
   endtask

   task automatic t_bad_marker_and_recover();
      int len;
      logic fell;
      do_reset();
      wait_release(len);
      send_ila(0, BAD_END, 0, fell);
      check(fell, "R5 missing end marker drops sync_n", fell, 1);
      check(lane_err == 2'b01, "R5 lane 0 blamed for marker", lane_err, 2'b01);
      check(!cfg_mismatch, "R5 marker fault is not a mismatch", cfg_mismatch, 0);
      wait_release(len);
      check(len == MIN_LOW, "R10 restart low time", len, MIN_LOW);
      send_ila(-1, NO_BAD, 0, fell);
      check(link_up, "R10 link recovers after restart", link_up, 1);
      check(lane_err == 2'b01, "R9 lane_err stays set", lane_err, 2'b01);
   endtask

   task automatic t_cfg_mismatch();
      int len;
      logic fell;
      do_reset();
      wait_release(len);
      send_ila(1, BAD_K, 0, fell);
      check(fell, "R6 mismatch drops sync_n at sequence end", fell, 1);
      check(cfg_mismatch, "R6 cfg_mismatch set", cfg_mismatch, 1);
      check(lane_err == 2'b10, "R6 lane 1 blamed for config", lane_err, 2'b10);
      check(!link_up, "R6 link_up stays low", link_up, 0);
      wait_release(len);
      send_ila(-1, NO_BAD, 0, fell);
      check(cfg_mismatch, "R9 cfg_mismatch sticky", cfg_mismatch, 1);
   endtask

   task automatic t_ignored_bits();
      int len;
      logic fell;
      do_reset();
      wait_release(len);
      send_ila(-1, HIGH_K, 0, fell);
      check(link_up, "R6 upper field bits ignored", link_up, 1);
      check(!cfg_mismatch, "R6 no mismatch from upper bits", cfg_mismatch, 0);
   endtask

   task automatic t_late_start();
      int len;
      logic fell;
      do_reset();
      wait_release(len);
      send_ila(-1, NO_BAD, 1, fell);
      check(fell, "R4 sequence off boundary drops sync_n", fell, 1);
      check(lane_err == 2'b11, "R4 both lanes blamed", lane_err, 2'b11);
   endtask

   task automatic t_lock_loss();
      int len;
      logic fell;
      do_reset();
      wait_release(len);
      send_ila(-1, NO_BAD, 0, fell);
      check(link_up, "R8 link up before fault", link_up, 1);
      put(0, 8'h12, 1'b0, 1'b0);
      put(1, 8'h34, 1'b0, 1'b1);
      tick();
      check(!sync_n, "R8 error drops sync_n", sync_n, 0);
      check(!link_up, "R8 error drops link_up", link_up, 0);
      check(lane_err == 2'b10, "R8 lane 1 flagged", lane_err, 2'b10);
      wait_release(len);
      check(len == MIN_LOW, "R3 low time after lock loss", len, MIN_LOW);
      send_ila(-1, NO_BAD, 0, fell);
      check(link_up, "R10 link up after lock loss", link_up, 1);
   endtask

   initial begin
      t_reset();
      t_fast_lock_and_clean();
      t_slow_lock();
      t_bad_marker_and_recover();
      t_cfg_mismatch();
      t_ignored_bits();
      t_late_start();
      t_lock_loss();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #500000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule